// File: doc/BRIEF.md
# Page Frame Tracker with Selectable Replacement

This block models a small, fully associative set of physical page frames. A stream of page identifiers arrives at its input, one per accepted cycle. For each one the block reports whether the page already sits in a frame (a hit) or not (a fault). On a fault the page is installed. If a frame is still empty, the lowest-numbered empty frame takes it. Once every frame is occupied, a victim frame is chosen and its page is reported as evicted.

The victim choice follows a static policy select. It can be oldest-loaded-first, least-recently-referenced, or least-often-referenced with a saturating per-frame use counter. Two running totals accompany the result stream: all faults, and compulsory misses. A compulsory miss is a fault on a page identifier that has not been presented since reset.

The reference input is a valid/ready interface. `ref_ready` is low while reset is asserted and high at all other times, so a reference is accepted on every clock edge where `ref_valid` is high after reset. The block never applies back-pressure. The result port carries only a valid strobe and cannot be stalled.

Top module: `page_frame_tracker`

## Requirements
- R1: A reference is accepted on a rising edge where `ref_valid` and `ref_ready` are both high. Its result appears with `res_valid` high in the cycle after that edge. `res_valid` is low after any edge that accepted nothing. `ref_ready` is low during reset and high otherwise.
- R2: When `res_valid` is high, exactly one of `res_hit` and `res_fault` is high. `res_hit` is high exactly when the referenced page was resident in some frame at the time it was accepted.
- R3: A fault that finds an empty frame fills the lowest-indexed empty frame. It leaves `res_evict` low.
- R4: Policy code 0 (oldest-first) evicts the page whose installation is earliest. Hits do not change this order.
- R5: Policy code 1 (least-recent) evicts the page whose latest reference, hit or install, is oldest. Every hit refreshes that page.
- R6: Policy code 2 (least-often) keeps a use count per frame. The count is set to 1 on install and incremented on each hit, saturating at 2^USE_W-1. The block evicts the frame with the smallest count, and the lowest frame index wins ties.
- R7: Policy code 3 behaves exactly as code 0.
- R8: `fault_count` increases by one on every fault and is unchanged on hits and idle cycles.
- R9: `compulsory_count` increases by one on a fault whose page identifier has not been accepted since reset.
- R10: When `res_evict` is high, `res_victim` carries the identifier of the page that was removed from its frame.
- R11: Reset empties all frames, clears both totals and forgets all previously seen identifiers. `policy` is changed only while reset is asserted.
- R12: The frame count is a parameter. With 3 frames, the reference stream B,E,E,R,B,A,R,E,B,E,A,R gives 7 faults (4 of them compulsory) under oldest-first and 8 faults under least-recent. The stream A,B,C,D,A,B,E,A,B,C,D,E under oldest-first gives 9 faults with 3 frames and 10 with 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| policy | input | 2 | Replacement policy: 0 oldest-first, 1 least-recent, 2 least-often, 3 same as 0 |
| ref_valid | input | 1 | A page reference is offered |
| ref_ready | output | 1 | Reference accepted when high together with ref_valid |
| ref_page | input | PAGE_W | Identifier of the referenced page |
| res_valid | output | 1 | Result of the previously accepted reference |
| res_hit | output | 1 | Reference found its page resident |
| res_fault | output | 1 | Reference missed and installed its page |
| res_evict | output | 1 | The fault displaced a resident page |
| res_victim | output | PAGE_W | Identifier of the displaced page |
| fault_count | output | CNT_W | Total faults since reset |
| compulsory_count | output | CNT_W | Faults on never-before-seen identifiers since reset |

## Verification
Two instances, with 3 and 4 frames, receive identical stimulus under all four policy codes. Both are compared reference by reference against a bench model that keeps load times, last-use times and use counts instead of an ordering.

The first two streams are short textbook streams with known fault totals. One separates oldest-first from least-recent on the same input. The other shows that adding a frame can raise the fault count under oldest-first.

A long pseudo-random stream over eight identifiers follows. It produces many evictions with mixed hit patterns, and it tells the policies apart wherever their victims differ. A final burst of repeated hits drives one use counter into saturation, and the evictions that come after it show whether least-often counting and tie breaking are correct.

// File: rtl/pft_pkg.sv
package pft_pkg;
  typedef enum logic [1:0] {
    POL_OLDEST = 2'd0,
    POL_RECENT = 2'd1,
    POL_OFTEN  = 2'd2,
    POL_ALIAS  = 2'd3
  } policy_e;
endpackage

// File: rtl/pft_lookup.sv
module pft_lookup #(
  parameter int FRAMES = 3,
  parameter int PAGE_W = 3,
  parameter int IDX_W  = 2
) (
  input  logic [FRAMES-1:0]             vld,
  input  logic [FRAMES-1:0][PAGE_W-1:0] page,
  input  logic [PAGE_W-1:0]             probe,
  output logic                          hit,
  output logic [IDX_W-1:0]              hit_idx,
  output logic                          free_any,
  output logic [IDX_W-1:0]              free_idx
);
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < FRAMES; i++) begin
      if (vld[i] && page[i] == probe && !hit) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    free_any = ~&vld;
    free_idx = '0;
    for (int i = FRAMES - 1; i >= 0; i--) begin
      if (!vld[i]) free_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/pft_victim.sv
module pft_victim #(
  parameter int FRAMES = 3,
  parameter int IDX_W  = 2,
  parameter int USE_W  = 4
) (
  input  pft_pkg::policy_e             pol,
  input  logic [FRAMES-1:0][IDX_W-1:0] rank,
  input  logic [FRAMES-1:0][USE_W-1:0] usecnt,
  output logic [IDX_W-1:0]             victim
);
  logic [USE_W-1:0] best;

  always_comb begin
    victim = '0;
    best   = usecnt[0];
    if (pol == pft_pkg::POL_OFTEN) begin
      for (int i = 1; i < FRAMES; i++) begin
        if (usecnt[i] < best) begin
          best   = usecnt[i];
          victim = IDX_W'(i);
        end
      end
    end else begin
      for (int i = FRAMES - 1; i >= 0; i--) begin
        if (rank[i] == '0) victim = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/page_frame_tracker.sv
module page_frame_tracker #(
  parameter int FRAMES = 3,
  parameter int PAGE_W = 3,
  parameter int USE_W  = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        policy,
  input  logic              ref_valid,
  output logic              ref_ready,
  input  logic [PAGE_W-1:0] ref_page,
  output logic              res_valid,
  output logic              res_hit,
  output logic              res_fault,
  output logic              res_evict,
  output logic [PAGE_W-1:0] res_victim,
  output logic [CNT_W-1:0]  fault_count,
  output logic [CNT_W-1:0]  compulsory_count
);
  localparam int IDX_W = (FRAMES > 1) ? $clog2(FRAMES) : 1;
  localparam int NV_W  = $clog2(FRAMES + 1);
  localparam int PAGES = 1 << PAGE_W;

  pft_pkg::policy_e pol;
  assign pol = pft_pkg::policy_e'(policy);

  logic [FRAMES-1:0]             vld_q, vld_d;
  logic [FRAMES-1:0][PAGE_W-1:0] page_q, page_d;
  logic [FRAMES-1:0][IDX_W-1:0]  rank_q, rank_d;
  logic [FRAMES-1:0][USE_W-1:0]  use_q, use_d;
  logic [PAGES-1:0]              seen_q, seen_d;
  logic [CNT_W-1:0]              fault_q, comp_q;
  logic                          ready_q, accept;
  logic                          hit, free_any;
  logic [IDX_W-1:0]              hit_idx, free_idx, victim_idx;
  logic [NV_W-1:0]               nvalid;
  logic                          n_hit, n_fault, n_evict, n_comp;
  logic [PAGE_W-1:0]             n_victim;

  assign accept    = ref_valid && ready_q;
  assign ref_ready = ready_q;

  pft_lookup #(.FRAMES(FRAMES), .PAGE_W(PAGE_W), .IDX_W(IDX_W)) u_lookup (
    .vld(vld_q), .page(page_q), .probe(ref_page),
    .hit(hit), .hit_idx(hit_idx), .free_any(free_any), .free_idx(free_idx)
  );

  pft_victim #(.FRAMES(FRAMES), .IDX_W(IDX_W), .USE_W(USE_W)) u_victim (
    .pol(pol), .rank(rank_q), .usecnt(use_q), .victim(victim_idx)
  );

  always_comb begin
    nvalid = '0;
    for (int i = 0; i < FRAMES; i++) nvalid = nvalid + NV_W'(vld_q[i]);
  end

  always_comb begin
    vld_d    = vld_q;
    page_d   = page_q;
    rank_d   = rank_q;
    use_d    = use_q;
    seen_d   = seen_q;
    n_hit    = 1'b0;
    n_fault  = 1'b0;
    n_evict  = 1'b0;
    n_comp   = 1'b0;
    n_victim = '0;
    if (accept) begin
      seen_d[ref_page] = 1'b1;
      if (hit) begin
        n_hit = 1'b1;
        if (use_q[hit_idx] != '1) use_d[hit_idx] = use_q[hit_idx] + 1'b1;
        if (pol == pft_pkg::POL_RECENT) begin
          for (int i = 0; i < FRAMES; i++) begin
            if (vld_q[i] && rank_q[i] > rank_q[hit_idx]) rank_d[i] = rank_q[i] - 1'b1;
          end
          rank_d[hit_idx] = IDX_W'(nvalid - 1'b1);
        end
      end else begin
        n_fault = 1'b1;
        n_comp  = !seen_q[ref_page];
        if (free_any) begin
          vld_d[free_idx]  = 1'b1;
          page_d[free_idx] = ref_page;
          rank_d[free_idx] = IDX_W'(nvalid);
          use_d[free_idx]  = USE_W'(1);
        end else begin
          n_evict  = 1'b1;
          n_victim = page_q[victim_idx];
          for (int i = 0; i < FRAMES; i++) begin
            if (rank_q[i] > rank_q[victim_idx]) rank_d[i] = rank_q[i] - 1'b1;
          end
          rank_d[victim_idx] = IDX_W'(FRAMES - 1);
          page_d[victim_idx] = ref_page;
          use_d[victim_idx]  = USE_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q      <= '0;
      page_q     <= '0;
      rank_q     <= '0;
      use_q      <= '0;
      seen_q     <= '0;
      fault_q    <= '0;
      comp_q     <= '0;
      ready_q    <= 1'b0;
      res_valid  <= 1'b0;
      res_hit    <= 1'b0;
      res_fault  <= 1'b0;
      res_evict  <= 1'b0;
      res_victim <= '0;
    end else begin
      vld_q      <= vld_d;
      page_q     <= page_d;
      rank_q     <= rank_d;
      use_q      <= use_d;
      seen_q     <= seen_d;
      fault_q    <= fault_q + CNT_W'(n_fault);
      comp_q     <= comp_q + CNT_W'(n_comp);
      ready_q    <= 1'b1;
      res_valid  <= accept;
      res_hit    <= n_hit;
      res_fault  <= n_fault;
      res_evict  <= n_evict;
      res_victim <= n_victim;
    end
  end

  assign fault_count      = fault_q;
  assign compulsory_count = comp_q;

  logic [FRAMES-1:0] rank_zero;
  always_comb begin
    for (int i = 0; i < FRAMES; i++) rank_zero[i] = vld_q[i] && rank_q[i] == '0;
  end

  assert_result_latency_R1: assert property (@(posedge clk) disable iff (rst)
    res_valid == $past(ref_valid && ref_ready));
  assert_one_outcome_R2: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_hit ^ res_fault));
  assert_evict_needs_fault_R3: assert property (@(posedge clk) disable iff (rst)
    res_evict |-> (res_valid && res_fault));
  assert_single_oldest_R4: assert property (@(posedge clk) disable iff (rst)
    (vld_q != '0) |-> ($countones(rank_zero) == 1));
  assert_fault_step_R8: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_fault) |-> (fault_count == $past(fault_count) + 1'b1));
  assert_comp_bound_R9: assert property (@(posedge clk) disable iff (rst)
    compulsory_count <= fault_count);
  assert_policy_hold_R11: assert property (@(posedge clk) disable iff (rst)
    $stable(policy));
endmodule

// File: tb/page_frame_tracker_bench.sv
module page_frame_tracker_bench;
  localparam int PAGE_W = 3;
  localparam int CNT_W  = 16;
  localparam int USE_W  = 4;
  localparam int USE_MAX = (1 << USE_W) - 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1;
  logic [1:0] policy = 2'd0;
  logic ref_valid = 1'b0;
  logic [PAGE_W-1:0] ref_page = '0;

  logic a_ready, a_valid, a_hit, a_fault, a_evict;
  logic [PAGE_W-1:0] a_victim;
  logic [CNT_W-1:0] a_faults, a_comp;
  logic b_ready, b_valid, b_hit, b_fault, b_evict;
  logic [PAGE_W-1:0] b_victim;
  logic [CNT_W-1:0] b_faults, b_comp;

  page_frame_tracker #(.FRAMES(3), .PAGE_W(PAGE_W), .USE_W(USE_W), .CNT_W(CNT_W)) u_page_frame_tracker (
    .clk(clk), .rst(rst), .policy(policy), .ref_valid(ref_valid), .ref_ready(a_ready),
    .ref_page(ref_page), .res_valid(a_valid), .res_hit(a_hit), .res_fault(a_fault),
    .res_evict(a_evict), .res_victim(a_victim), .fault_count(a_faults), .compulsory_count(a_comp));

  page_frame_tracker #(.FRAMES(4), .PAGE_W(PAGE_W), .USE_W(USE_W), .CNT_W(CNT_W)) u_page_frame_tracker_f4 (
    .clk(clk), .rst(rst), .policy(policy), .ref_valid(ref_valid), .ref_ready(b_ready),
    .ref_page(ref_page), .res_valid(b_valid), .res_hit(b_hit), .res_fault(b_fault),
    .res_evict(b_evict), .res_victim(b_victim), .fault_count(b_faults), .compulsory_count(b_comp));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int cur_pol = 0;
  int tnow = 0;

  int m_vld[2][4], m_page[2][4], m_load[2][4], m_last[2][4], m_cnt[2][4];
  int m_seen[2][8];
  int m_f[2], m_c[2];
  int e_hit[2], e_evict[2], e_victim[2];

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < 4; i++) begin
        m_vld[m][i] = 0; m_page[m][i] = 0; m_load[m][i] = 0; m_last[m][i] = 0; m_cnt[m][i] = 0;
      end
      for (int p = 0; p < 8; p++) m_seen[m][p] = 0;
      m_f[m] = 0; m_c[m] = 0;
    end
    tnow = 0;
  endtask

  task automatic model_step(int m, int nf, int pg);
    int h = -1;
    int fr = -1;
    for (int i = 0; i < nf; i++) if (m_vld[m][i] != 0 && m_page[m][i] == pg && h < 0) h = i;
    e_evict[m] = 0;
    e_victim[m] = 0;
    if (h >= 0) begin
      e_hit[m] = 1;
      if (m_cnt[m][h] < USE_MAX) m_cnt[m][h]++;
      m_last[m][h] = tnow;
    end else begin
      e_hit[m] = 0;
      m_f[m]++;
      if (m_seen[m][pg] == 0) m_c[m]++;
      for (int i = nf - 1; i >= 0; i--) if (m_vld[m][i] == 0) fr = i;
      if (fr < 0) begin
        fr = 0;
        for (int i = 1; i < nf; i++) begin
          if (cur_pol == 1) begin
            if (m_last[m][i] < m_last[m][fr]) fr = i;
          end else if (cur_pol == 2) begin
            if (m_cnt[m][i] < m_cnt[m][fr]) fr = i;
          end else begin
            if (m_load[m][i] < m_load[m][fr]) fr = i;
          end
        end
        e_evict[m] = 1;
        e_victim[m] = m_page[m][fr];
      end
      m_vld[m][fr] = 1; m_page[m][fr] = pg; m_load[m][fr] = tnow;
      m_last[m][fr] = tnow; m_cnt[m][fr] = 1;
    end
    m_seen[m][pg] = 1;
  endtask

  function automatic string pol_req();
    if (cur_pol == 1) return "R5";
    if (cur_pol == 2) return "R6";
    if (cur_pol == 3) return "R7";
    return "R4";
  endfunction

  task automatic compare(int m, logic v, logic h, logic f, logic ev, logic [PAGE_W-1:0] vic,
                         logic [CNT_W-1:0] fc, logic [CNT_W-1:0] cc);
    string pr = pol_req();
    chk("R1", "res_valid", int'(v), 1);
    chk("R2", "res_hit", int'(h), e_hit[m]);
    chk("R2", "res_fault", int'(f), 1 - e_hit[m]);
    if (e_hit[m] == 0 && e_evict[m] == 0) chk("R3", "res_evict with free frame", int'(ev), 0);
    else chk(pr, "res_evict", int'(ev), e_evict[m]);
    if (e_evict[m] != 0) begin
      chk(pr, "victim choice", int'(vic), e_victim[m]);
      chk("R10", "res_victim", int'(vic), e_victim[m]);
    end
    chk("R8", "fault_count", int'(fc), m_f[m]);
    chk("R9", "compulsory_count", int'(cc), m_c[m]);
  endtask

  task automatic send(int pg);
    ref_valid = 1'b1;
    ref_page  = PAGE_W'(pg);
    tnow++;
    model_step(0, 3, pg);
    model_step(1, 4, pg);
    @(posedge clk);
    @(negedge clk);
    compare(0, a_valid, a_hit, a_fault, a_evict, a_victim, a_faults, a_comp);
    compare(1, b_valid, b_hit, b_fault, b_evict, b_victim, b_faults, b_comp);
  endtask

  task automatic idle_check();
    ref_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R1", "res_valid after idle", int'(a_valid), 0);
    chk("R8", "fault_count unchanged on idle", int'(a_faults), m_f[0]);
  endtask

  task automatic do_reset(int pol);
    @(negedge clk);
    ref_valid = 1'b0;
    rst = 1'b1;
    policy = 2'(pol);
    cur_pol = pol;
    repeat (3) @(negedge clk);
    chk("R1", "ref_ready during reset", int'(a_ready), 0);
    rst = 1'b0;
    model_clear();
    @(posedge clk);
    @(negedge clk);
    chk("R1", "ref_ready after reset", int'(a_ready), 1);
    chk("R11", "res_valid after reset", int'(a_valid), 0);
    chk("R11", "fault_count after reset", int'(a_faults), 0);
    chk("R11", "compulsory_count after reset", int'(a_comp), 0);
    chk("R11", "4-frame fault_count after reset", int'(b_faults), 0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] seed;
    int beer[12]   = '{1, 2, 2, 3, 1, 0, 3, 2, 1, 2, 0, 3};
    int belady[12] = '{0, 1, 2, 3, 0, 1, 4, 0, 1, 2, 3, 4};
    for (int pol = 0; pol < 4; pol++) begin
      do_reset(pol);
      foreach (beer[k]) send(beer[k]);
      if (pol == 0 || pol == 3) begin
        chk("R12", "3-frame faults, first stream, oldest-first", int'(a_faults), 7);
        chk("R12", "3-frame compulsory, first stream", int'(a_comp), 4);
      end
      if (pol == 1) chk("R12", "3-frame faults, first stream, least-recent", int'(a_faults), 8);
      idle_check();

      do_reset(pol);
      foreach (belady[k]) send(belady[k]);
      if (pol == 0 || pol == 3) begin
        chk("R12", "3-frame faults, second stream", int'(a_faults), 9);
        chk("R12", "4-frame faults, second stream", int'(b_faults), 10);
      end

      do_reset(pol);
      seed = 32'h1234_5678 + 32'(pol);
      for (int n = 0; n < 300; n++) begin
        seed = seed * 32'd1103515245 + 32'd12345;
        send(int'(seed[18:16]));
      end
      for (int n = 0; n < 20; n++) send(5);
      send(6); send(7); send(0); send(1); send(5); send(2);
      idle_check();
    end
    done = 1'b1;
    finish_run();
  end
endmodule